// File: doc/BRIEF.md
# Audio Clock Mux-Divide-Gate Tree

This block derives three audio clocks from three reference clocks: a shared audio PLL clock and two serial-port clocks, one per port. A single 32-bit control word is written over a simple synchronous write bus. It chooses the source for two independent selection paths, sets three one-based integer dividers and opens or closes three output gates.

The first path feeds both the system clock and the port-0 bit clock. The second path feeds only the port-1 bit clock. All logic runs on one fast sampling clock `clk`. The reference clocks are synchronised and their edges are counted. The outputs are registered clock levels, so a source switch, a divider change or a gate change can never produce a runt pulse.

Top module: `aud_clk_tree`

## Requirements
- R1: While and after a synchronous high `rst`, the control word is zero: all three outputs are low, all gates are closed and both paths select the PLL clock.
- R2: Only a write with `bus_wr` high and `bus_addr` equal to 0x04 updates the control word. Writes to any other address leave every output unchanged.
- R3: Gate bits sit at 0 (system), 8 (port 0) and 16 (port 1), and 1 opens the gate. A closed gate holds its output low. A gate bit change takes effect only while the divided clock is low, so no high pulse is ever shortened.
- R4: The divider fields are bits 6:1 (system), 14:9 (port 0) and 22:17 (port 1). A field value N in 1..63 makes the output toggle once every N edges of the selected source, which gives an output period of N source periods.
- R5: A divider field of zero acts as divide-by-1 and never stalls the output.
- R6: A new divider value is taken only at a terminal count, that is, in the cycle the divided clock toggles.
- R7: Bit 7 picks the source shared by the system and port-0 clocks (0 = PLL, 1 = port-0 serial clock). Bit 23 picks the port-1 source (0 = PLL, 1 = port-1 serial clock).
- R8: A path changes source only in a cycle where the synchronised levels of both its candidate sources are low.
- R9: The system and port-0 dividers count edges of the same selected source, so a switch of bit 7 moves both clocks at once.
- R10: A source edge reaches a gated output on the fifth rising edge of `clk` after it is sampled. That is two synchroniser flops, one path register, one divider register and one gate register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 32 | Write data |
| pll_clk | input | 1 | Audio PLL reference clock |
| i2s0_clk | input | 1 | Port-0 serial reference clock |
| i2s1_clk | input | 1 | Port-1 serial reference clock |
| sys_clk_out | output | 1 | Gated system clock |
| p0_clk_out | output | 1 | Gated port-0 bit clock |
| p1_clk_out | output | 1 | Gated port-1 bit clock |

## Verification
Two events can land in the same cycle: a control write that changes a divider or gate, and a divider toggle at terminal count. A source switch can also coincide with a pending divider reload. The bench provokes both by writing new settings while the reference clocks run with unequal, non-multiple periods, so the writes fall on many different phases of the counters. The outputs are compared every cycle against a behavioural model, and rising edges are also counted over windows against the period each setting implies.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
  localparam int CTRL_W   = 32;
  localparam int DIV_W    = 6;
  localparam int NUM_SRC  = 3;
  localparam int NUM_PATH = 2;
  localparam int NUM_OUT  = 3;

  // Output k: 0 = system, 1 = port 0, 2 = port 1.
  function automatic int gate_bit(input int k);
    return 8 * k;
  endfunction

  function automatic int div_lsb(input int k);
    return 8 * k + 1;
  endfunction

  // Path 0 serves system and port 0, path 1 serves port 1.
  function automatic int sel_bit(input int p);
    return (p == 0) ? 7 : 23;
  endfunction

  function automatic int path_of(input int k);
    return (k == 2) ? 1 : 0;
  endfunction
endpackage

// File: rtl/aud_clk_sync.sv
module aud_clk_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_clk_gfmux.sv
module aud_clk_gfmux (
  input  logic clk,
  input  logic rst,
  input  logic lvl_a,
  input  logic lvl_b,
  input  logic sel_want,
  output logic edge_o
);
  logic act_q;
  logic lvl_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= act_q ? lvl_b : lvl_a;
      prev_q <= lvl_q;
      if (sel_want != act_q && !lvl_a && !lvl_b) act_q <= sel_want;
    end
  end

  assign edge_o = lvl_q ^ prev_q;

  assert_switch_when_low_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(!lvl_a && !lvl_b));

  assert_follow_selected_R7: assert property (@(posedge clk) disable iff (rst)
    act_q |=> (lvl_q == $past(lvl_b)));
endmodule

// File: rtl/aud_clk_div.sv
module aud_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [DIV_W-1:0] field_i,
  output logic             div_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= DIV_W'(1);
      div_o <= 1'b0;
    end else if (edge_i) begin
      if (cnt_q == act_q - 1'b1) begin
        cnt_q <= '0;
        div_o <= ~div_o;
        act_q <= (field_i == '0) ? DIV_W'(1) : field_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_toggle_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_o) |-> $past(edge_i));

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < act_q);

  assert_never_zero_R5: assert property (@(posedge clk) disable iff (rst)
    act_q != '0);

  assert_reload_at_terminal_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> !$stable(div_o));
endmodule

// File: rtl/aud_clk_gate.sv
module aud_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic div_i,
  input  logic en_i,
  output logic out_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      out_o <= 1'b0;
    end else begin
      if (!div_i) en_q <= en_i;
      out_o <= div_i & en_q;
    end
  end

  assert_enable_moves_low_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> !$past(div_i));

  assert_high_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    out_o |-> $past(en_q && div_i));
endmodule

// File: rtl/aud_clk_tree.sv
module aud_clk_tree
  import aud_clk_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h04,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  input  logic              pll_clk,
  input  logic              i2s0_clk,
  input  logic              i2s1_clk,
  output logic              sys_clk_out,
  output logic              p0_clk_out,
  output logic              p1_clk_out
);
  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0]  src_s;
  logic [NUM_PATH-1:0] path_edge;
  logic [NUM_OUT-1:0]  div_clk;
  logic [NUM_OUT-1:0]  gated;
  logic                unused_ctrl;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_wr && bus_addr == CTRL_ADDR) ctrl_q <= bus_wdata;
  end

  assign unused_ctrl = ^{ctrl_q[CTRL_W-1:24], ctrl_q[15]};

  aud_clk_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({i2s1_clk, i2s0_clk, pll_clk}), .q(src_s)
  );

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    aud_clk_gfmux u_mux (
      .clk(clk), .rst(rst), .lvl_a(src_s[0]), .lvl_b(src_s[p+1]),
      .sel_want(ctrl_q[sel_bit(p)]), .edge_o(path_edge[p])
    );
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    aud_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .edge_i(path_edge[path_of(k)]),
      .field_i(ctrl_q[div_lsb(k) +: DIV_W]), .div_o(div_clk[k])
    );
    aud_clk_gate u_gate (
      .clk(clk), .rst(rst), .div_i(div_clk[k]),
      .en_i(ctrl_q[gate_bit(k)]), .out_o(gated[k])
    );
  end

  assign sys_clk_out = gated[0];
  assign p0_clk_out  = gated[1];
  assign p1_clk_out  = gated[2];

  assert_write_only_at_offset_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q) |-> $past(bus_wr && bus_addr == CTRL_ADDR));
endmodule

// File: tb/aud_clk_tree_tb_top.sv
`timescale 1ns/1ps
module aud_clk_tree_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic        pll_clk = 1'b0, i2s0_clk = 1'b0, i2s1_clk = 1'b0;
  logic        sys_clk_out, p0_clk_out, p1_clk_out;

  always #2.5 clk = ~clk;

  aud_clk_tree dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pll_clk(pll_clk), .i2s0_clk(i2s0_clk), .i2s1_clk(i2s1_clk),
    .sys_clk_out(sys_clk_out), .p0_clk_out(p0_clk_out), .p1_clk_out(p1_clk_out)
  );

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 0;

  // source generators: half periods in clk cycles
  int hp[3] = '{3, 5, 4};
  int gcnt[3] = '{0, 0, 0};
  int glvl[3] = '{0, 0, 0};

  // behavioural reference state
  int s1[3], s2[3];
  int act[2], mq[2], mp[2];
  int cnt[3], dv[3], dact[3], en[3], gout[3];
  logic [31:0] mctrl;

  int rises[3] = '{0, 0, 0};
  int prev_o[3] = '{0, 0, 0};

  function automatic int dut_out(input int k);
    case (k)
      0:       return int'(sys_clk_out);
      1:       return int'(p0_clk_out);
      default: return int'(p1_clk_out);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int actual, input int expected,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
    end
  endtask

  task automatic model_step();
    int n_s1[3], n_s2[3], n_act[2], n_mq[2], n_mp[2];
    int n_cnt[3], n_dv[3], n_dact[3], n_en[3], n_gout[3];
    int srcv[3];
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        s1[i] = 0; s2[i] = 0; cnt[i] = 0; dv[i] = 0; dact[i] = 1; en[i] = 0; gout[i] = 0;
      end
      for (int p = 0; p < 2; p++) begin act[p] = 0; mq[p] = 0; mp[p] = 0; end
      mctrl = 32'h0;
      return;
    end
    srcv[0] = int'(pll_clk); srcv[1] = int'(i2s0_clk); srcv[2] = int'(i2s1_clk);
    for (int i = 0; i < 3; i++) begin n_s1[i] = srcv[i]; n_s2[i] = s1[i]; end
    for (int p = 0; p < 2; p++) begin
      int a, b, want;
      a = s2[0]; b = s2[p+1];
      want = (p == 0) ? int'(mctrl[7]) : int'(mctrl[23]);
      n_mq[p]  = (act[p] != 0) ? b : a;
      n_mp[p]  = mq[p];
      n_act[p] = (want != act[p] && a == 0 && b == 0) ? want : act[p];
    end
    for (int k = 0; k < 3; k++) begin
      int p, fld;
      p = (k == 2) ? 1 : 0;
      fld = int'((mctrl >> (8 * k + 1)) & 32'h3f);
      n_cnt[k] = cnt[k]; n_dv[k] = dv[k]; n_dact[k] = dact[k];
      if (mq[p] != mp[p]) begin
        if (cnt[k] == dact[k] - 1) begin
          n_cnt[k] = 0; n_dv[k] = 1 - dv[k]; n_dact[k] = (fld == 0) ? 1 : fld;
        end else begin
          n_cnt[k] = cnt[k] + 1;
        end
      end
      n_en[k]   = (dv[k] == 0) ? int'(mctrl[8 * k]) : en[k];
      n_gout[k] = dv[k] & en[k];
    end
    if (bus_wr && bus_addr == 8'h04) mctrl = bus_wdata;
    for (int i = 0; i < 3; i++) begin
      s1[i] = n_s1[i]; s2[i] = n_s2[i];
      cnt[i] = n_cnt[i]; dv[i] = n_dv[i]; dact[i] = n_dact[i]; en[i] = n_en[i]; gout[i] = n_gout[i];
    end
    for (int p = 0; p < 2; p++) begin act[p] = n_act[p]; mq[p] = n_mq[p]; mp[p] = n_mp[p]; end
  endtask

  task automatic tick();
    int o;
    @(negedge clk);
    model_step();
    for (int k = 0; k < 3; k++) begin
      o = dut_out(k);
      check(o == gout[k], tag, o, gout[k], $sformatf("output %0d per-cycle", k));
      if (o == 1 && prev_o[k] == 0) rises[k]++;
      prev_o[k] = o;
    end
    for (int i = 0; i < 3; i++) begin
      gcnt[i]++;
      if (gcnt[i] >= hp[i]) begin gcnt[i] = 0; glvl[i] = 1 - glvl[i]; end
    end
    pll_clk  = glvl[0][0];
    i2s0_clk = glvl[1][0];
    i2s1_clk = glvl[2][0];
    bus_wr   = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  function automatic logic [31:0] cfg(input int g0, input int d0, input int sel0,
                                      input int g1, input int d1,
                                      input int g2, input int d2, input int sel1);
    logic [31:0] v;
    v = 32'h0;
    v[0] = g0[0];  v[6:1]   = d0[5:0]; v[7]  = sel0[0];
    v[8] = g1[0];  v[14:9]  = d1[5:0];
    v[16] = g2[0]; v[22:17] = d2[5:0]; v[23] = sel1[0];
    return v;
  endfunction

  task automatic window(input int n);
    for (int k = 0; k < 3; k++) rises[k] = 0;
    repeat (n) tick();
  endtask

  task automatic range_check(input string req, input int k, input int lo, input int hi);
    check(rises[k] >= lo && rises[k] <= hi, req, rises[k], (lo + hi) / 2,
          $sformatf("rising edges on output %0d", k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (4) tick();
    check(sys_clk_out == 0 && p0_clk_out == 0 && p1_clk_out == 0, "R1",
          {sys_clk_out, p0_clk_out, p1_clk_out}, 0, "outputs in reset");
    rst = 1'b0;
    window(30);
    range_check("R1", 0, 0, 0);

    // R2: write to a different offset is ignored
    tag = "R2";
    bus_write(8'h08, 32'hFFFF_FFFF);
    window(60);
    range_check("R2", 0, 0, 0); range_check("R2", 1, 0, 0); range_check("R2", 2, 0, 0);

    // R4, R5, R10: PLL source (period 6): system /1, port0 /3, port1 field 0
    tag = "R4 R5 R10";
    bus_write(8'h04, cfg(1, 1, 0, 1, 3, 1, 0, 0));
    repeat (60) tick();
    window(180);
    range_check("R4", 0, 29, 31);
    range_check("R4", 1, 9, 11);
    range_check("R5", 2, 29, 31);

    // R6: reprogram dividers while running
    tag = "R6";
    bus_write(8'h04, cfg(1, 2, 0, 1, 5, 1, 0, 0));
    repeat (100) tick();
    window(300);
    range_check("R6", 0, 24, 26);
    range_check("R6", 1, 9, 11);

    // R7, R8, R9: shared path moves to port-0 serial clock (period 10)
    tag = "R7 R8 R9";
    bus_write(8'h04, cfg(1, 2, 1, 1, 5, 1, 0, 0));
    repeat (100) tick();
    window(300);
    range_check("R9", 0, 14, 16);
    range_check("R9", 1, 5, 7);
    range_check("R7", 2, 49, 51);

    // R7, R8: port-1 path moves to its serial clock (period 8)
    bus_write(8'h04, cfg(1, 2, 1, 1, 5, 1, 0, 1));
    repeat (60) tick();
    window(160);
    range_check("R7", 2, 19, 21);

    // R3: close the port-0 gate, others keep running
    tag = "R3";
    bus_write(8'h04, cfg(1, 2, 1, 0, 5, 1, 0, 1));
    repeat (60) tick();
    window(200);
    range_check("R3", 1, 0, 0);
    range_check("R3", 0, 9, 11);

    // R4 boundary: largest divider on port 1, back on PLL (period 378)
    tag = "R4 boundary";
    bus_write(8'h04, cfg(1, 2, 0, 1, 1, 1, 63, 0));
    repeat (800) tick();
    window(1134);
    range_check("R4", 2, 2, 4);
    range_check("R4", 1, 188, 190);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule